// File: doc/BRIEF.md
# Prioritized Interrupt Source Resolver

This block looks at the masked pending words of a three-bank interrupt controller and names the one source that software should service next. The first word (the summary word) carries eight direct sources of bank 0, two groups of fast-path bits that each stand for one particular source in bank 1 or bank 2, and one summary bit for each of banks 1 and 2. The other two words are the full pending words of banks 1 and 2. The resolver walks a fixed priority order over these groups, picks the lowest set bit inside the winning group, and encodes the result as a 7-bit source number: the bank in bits 6:5 and the bit index within that bank in bits 4:0.

The result is registered and offered on a valid/ready output. The resolver re-evaluates every cycle from the current pending words, so a consumer sees a fresh choice one cycle after the inputs move. When the consumer stalls a valid result (valid high, ready low), the register holds its number unchanged until ready is seen; when valid is low, or ready is high, the next choice is loaded. Ready never affects the error flag. A summary bit that points at an empty bank word is an inconsistency: the output then carries no valid source and a one-cycle error flag is raised.

Top module: `irq_source_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_id and err_pulse are all 0.
- R2: out_id holds bank in bits 6:5 (0, 1 or 2) and the bit index within the bank in bits 4:0, i.e. bank*32 + index.
- R3: Groups are tried in this order: summary bits 7:0 (bank 0 direct), bits 14:10, bits 20:15, bit 8 (bank 1 scan), bit 9 (bank 2 scan); the first group with any bit set decides.
- R4: Inside the deciding group the lowest-numbered set bit is taken.
- R5: A hit at summary bit 10+k (k = 0..4) selects bank 1 with index 7, 9, 10, 18, 19 for k = 0, 1, 2, 3, 4, without looking at the bank 1 word.
- R6: A hit at summary bit 15+k (k = 0..5) selects bank 2 with index 21, 22, 23, 24, 25, 30 for k = 0..5, without looking at the bank 2 word.
- R7: When bit 8 (or bit 9) decides, the index is the lowest set bit of the bank 1 (or bank 2) pending word.
- R8: With summary bits 20:0 all clear the loaded result has out_valid 0 and out_id 0; summary bits 31:21 have no effect.
- R9: The output register loads the choice made from the inputs present at the previous clock edge (one cycle of latency).
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_id keep their values at the next edge.
- R11: If bit 8 or bit 9 decides but the matching bank word is zero, the loaded result has out_valid 0 and out_id 0, and err_pulse is 1 for exactly one cycle at the start of such a fault, low while it persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| summary_word | input | 32 | Masked bank 0 pending word with fast-path and summary bits |
| bank1_word | input | 32 | Masked bank 1 pending word |
| bank2_word | input | 32 | Masked bank 2 pending word |
| out_ready | input | 1 | Consumer accepts the offered source number |
| out_valid | output | 1 | A source number is offered |
| out_id | output | 7 | Source number, bank in 6:5, index in 4:0 |
| err_pulse | output | 1 | One-cycle flag for a summary bit with an empty bank word |

## Verification
The hardest case to reach from the ports is a stalled valid result while the inputs keep changing underneath it, including a fault arriving mid-stall: the register must hold its number while the error flag still follows the inputs. The stimulus drops out_ready in bursts during sparse random pending patterns and during directed fault entries, so held values and fresh faults overlap. The one-shot nature of the error flag is driven by keeping a fault present over several cycles, then switching between bank 1 and bank 2 faults without a clean cycle between them.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;
  localparam int BANK_W = 2;
  localparam int ID_W   = BANK_W + IDX_W;

  localparam int DIRECT_N = 8;
  localparam int FAST1_LO = 10;
  localparam int FAST1_N  = 5;
  localparam int FAST2_LO = 15;
  localparam int FAST2_N  = 6;
  localparam int SUM1_BIT = 8;
  localparam int SUM2_BIT = 9;
  localparam int LIVE_HI  = FAST2_LO + FAST2_N - 1;

  // fast-path lookup lists, entry k in bits [k*5 +: 5]
  localparam logic [FAST1_N*IDX_W-1:0] FAST1_LUT =
    {5'd19, 5'd18, 5'd10, 5'd9, 5'd7};
  localparam logic [FAST2_N*IDX_W-1:0] FAST2_LUT =
    {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21};

  typedef struct packed {
    logic            valid;
    logic            fault;
    logic [ID_W-1:0] id;
  } pick_t;

  function automatic logic [ID_W-1:0] make_id(input logic [BANK_W-1:0] bank,
                                              input logic [IDX_W-1:0] idx);
    return {bank, idx};
  endfunction
endpackage

// File: rtl/irq_lsb_finder.sv
module irq_lsb_finder #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_fast_map.sv
module irq_fast_map #(
  parameter int N  = 5,
  parameter int IW = 3,
  parameter logic [N*irq_resolver_pkg::IDX_W-1:0] LUT = '0
) (
  input  logic [IW-1:0]                      pos,
  output logic [irq_resolver_pkg::IDX_W-1:0] bank_idx
);
  import irq_resolver_pkg::*;
  logic [IDX_W-1:0] entry [N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_entry
      assign entry[k] = LUT[k*IDX_W +: IDX_W];
    end
  endgenerate

  always_comb begin
    bank_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (pos == IW'(k)) bank_idx = entry[k];
    end
  end
endmodule

// File: rtl/irq_priority_select.sv
module irq_priority_select
  import irq_resolver_pkg::*;
(
  input  logic [WORD_W-1:0] summary_word,
  input  logic [WORD_W-1:0] bank1_word,
  input  logic [WORD_W-1:0] bank2_word,
  output pick_t             pick
);
  localparam int DIW = $clog2(DIRECT_N);
  localparam int F1W = $clog2(FAST1_N);
  localparam int F2W = $clog2(FAST2_N);

  logic           dir_any, f1_any, f2_any, b1_any, b2_any;
  logic [DIW-1:0] dir_idx;
  logic [F1W-1:0] f1_pos;
  logic [F2W-1:0] f2_pos;
  logic [IDX_W-1:0] f1_idx, f2_idx, b1_idx, b2_idx;

  irq_lsb_finder #(.W(DIRECT_N)) u_direct (
    .vec(summary_word[DIRECT_N-1:0]), .any(dir_any), .idx(dir_idx));
  irq_lsb_finder #(.W(FAST1_N)) u_fast1 (
    .vec(summary_word[FAST1_LO +: FAST1_N]), .any(f1_any), .idx(f1_pos));
  irq_lsb_finder #(.W(FAST2_N)) u_fast2 (
    .vec(summary_word[FAST2_LO +: FAST2_N]), .any(f2_any), .idx(f2_pos));
  irq_lsb_finder #(.W(WORD_W)) u_scan1 (
    .vec(bank1_word), .any(b1_any), .idx(b1_idx));
  irq_lsb_finder #(.W(WORD_W)) u_scan2 (
    .vec(bank2_word), .any(b2_any), .idx(b2_idx));

  irq_fast_map #(.N(FAST1_N), .IW(F1W), .LUT(FAST1_LUT)) u_map1 (
    .pos(f1_pos), .bank_idx(f1_idx));
  irq_fast_map #(.N(FAST2_N), .IW(F2W), .LUT(FAST2_LUT)) u_map2 (
    .pos(f2_pos), .bank_idx(f2_idx));

  always_comb begin
    pick = '0;
    if (dir_any) begin
      pick.valid = 1'b1;
      pick.id    = make_id(2'd0, IDX_W'(dir_idx));
    end else if (f1_any) begin
      pick.valid = 1'b1;
      pick.id    = make_id(2'd1, f1_idx);
    end else if (f2_any) begin
      pick.valid = 1'b1;
      pick.id    = make_id(2'd2, f2_idx);
    end else if (summary_word[SUM1_BIT]) begin
      pick.valid = b1_any;
      pick.fault = !b1_any;
      pick.id    = b1_any ? make_id(2'd1, b1_idx) : '0;
    end else if (summary_word[SUM2_BIT]) begin
      pick.valid = b2_any;
      pick.fault = !b2_any;
      pick.id    = b2_any ? make_id(2'd2, b2_idx) : '0;
    end
  end
endmodule

// File: rtl/irq_source_resolver.sv
module irq_source_resolver
  import irq_resolver_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] summary_word,
  input  logic [WORD_W-1:0] bank1_word,
  input  logic [WORD_W-1:0] bank2_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic              err_pulse
);
  pick_t pick;
  logic  fault_q;
  logic  load;

  irq_priority_select u_select (
    .summary_word(summary_word),
    .bank1_word  (bank1_word),
    .bank2_word  (bank2_word),
    .pick        (pick)
  );

  assign load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_id    <= '0;
      fault_q   <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      if (load) begin
        out_valid <= pick.valid;
        out_id    <= pick.id;
      end
      fault_q   <= pick.fault;
      err_pulse <= pick.fault && !fault_q;
    end
  end
endmodule

// File: rtl/irq_source_resolver_checker.sv
module irq_source_resolver_checker
  import irq_resolver_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] summary_word,
  input logic              out_ready,
  input logic              out_valid,
  input logic [ID_W-1:0]   out_id,
  input logic              err_pulse
);
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));

  assert_idle_id_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_id == '0));

  assert_quiet_inputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && (summary_word[LIVE_HI:0] == '0)) |=> !out_valid);

  assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  assert_bank_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id[ID_W-1 -: BANK_W] != 2'd3));

  assert_direct_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_id[ID_W-1 -: BANK_W] == 2'd0) |-> (out_id[IDX_W-1:0] < DIRECT_N));
endmodule

bind irq_source_resolver irq_source_resolver_checker u_checker (
  .clk(clk), .rst_n(rst_n), .summary_word(summary_word), .out_ready(out_ready),
  .out_valid(out_valid), .out_id(out_id), .err_pulse(err_pulse));

// File: tb/irq_source_resolver_bench.sv
module irq_source_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] summary_word = '0;
  logic [31:0] bank1_word = '0;
  logic [31:0] bank2_word = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [6:0]  out_id;
  logic        err_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  logic       exp_valid = 0;
  logic [6:0] exp_id = 0;
  logic       exp_err = 0;
  logic       exp_fault_prev = 0;

  always #4 clk = ~clk;

  irq_source_resolver u_irq_source_resolver (
    .clk(clk), .rst_n(rst_n), .summary_word(summary_word),
    .bank1_word(bank1_word), .bank2_word(bank2_word), .out_ready(out_ready),
    .out_valid(out_valid), .out_id(out_id), .err_pulse(err_pulse));

  function automatic int lowest(input logic [31:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) if (w[i]) return i;
    return -1;
  endfunction

  // behavioural choice: {valid, fault, id}
  task automatic choose(output logic v, output logic f, output logic [6:0] id);
    int p;
    int list1 [5] = '{7, 9, 10, 18, 19};
    int list2 [6] = '{21, 22, 23, 24, 25, 30};
    v = 0; f = 0; id = 0;
    p = lowest(summary_word, 0, 7);
    if (p >= 0) begin v = 1; id = 7'(p); return; end
    p = lowest(summary_word, 10, 14);
    if (p >= 0) begin v = 1; id = 7'(32 + list1[p-10]); return; end
    p = lowest(summary_word, 15, 20);
    if (p >= 0) begin v = 1; id = 7'(64 + list2[p-15]); return; end
    if (summary_word[8]) begin
      p = lowest(bank1_word, 0, 31);
      if (p >= 0) begin v = 1; id = 7'(32 + p); end else f = 1;
      return;
    end
    if (summary_word[9]) begin
      p = lowest(bank2_word, 0, 31);
      if (p >= 0) begin v = 1; id = 7'(64 + p); end else f = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 0; exp_id = 0; exp_err = 0; exp_fault_prev = 0;
    end else begin
      logic v, f;
      logic [6:0] id;
      choose(v, f, id);
      if (!exp_valid || out_ready) begin
        exp_valid = v;
        exp_id = id;
      end
      exp_err = f && !exp_fault_prev;
      exp_fault_prev = f;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      checks++;
      if (out_valid !== exp_valid || out_id !== exp_id) begin
        errors++;
        $display("FAIL %s: valid/id actual %0b/%0d expected %0b/%0d at cycle %0d",
                 tag, out_valid, out_id, exp_valid, exp_id, cycles);
      end
      checks++;
      if (err_pulse !== exp_err) begin
        errors++;
        $display("FAIL %s: err_pulse actual %0b expected %0b at cycle %0d",
                 tag, err_pulse, exp_err, cycles);
      end
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic step(input logic [31:0] s, input logic [31:0] b1,
                      input logic [31:0] b2, input logic rdy, input string t);
    @(posedge clk); #2;
    summary_word = s; bank1_word = b1; bank2_word = b2; out_ready = rdy; tag = t;
  endtask

  // directed point check two edges after a stimulus (R9 latency)
  task automatic expect_id(input logic [31:0] s, input logic [31:0] b1,
                           input logic [31:0] b2, input logic v, input int id,
                           input string t);
    step(s, b1, b2, 1'b1, t);
    @(negedge clk); @(negedge clk); #1;
    checks++;
    if (out_valid !== v || out_id !== 7'(id)) begin
      errors++;
      $display("FAIL %s: actual %0b/%0d expected %0b/%0d", t, out_valid, out_id, v, id);
    end
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || out_id !== 0 || err_pulse !== 0) begin
      errors++;
      $display("FAIL R1: actual %0b/%0d/%0b expected 0/0/0", out_valid, out_id, err_pulse);
    end
    rst_n = 1'b1;

    // R2 R4 direct bank 0 lowest bit
    expect_id(32'h0000_00A8, 0, 0, 1, 3, "R4");
    expect_id(32'h0000_0080, 0, 0, 1, 7, "R2");
    // R3 direct beats fast paths and summaries
    expect_id(32'h001F_FF40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 6, "R3");
    // R5 each fast-path entry of group one
    expect_id(32'h0000_0400, 0, 0, 1, 32 + 7, "R5");
    expect_id(32'h0000_0800, 0, 0, 1, 32 + 9, "R5");
    expect_id(32'h0000_1000, 0, 0, 1, 32 + 10, "R5");
    expect_id(32'h0000_2000, 0, 0, 1, 32 + 18, "R5");
    expect_id(32'h0000_4000, 0, 0, 1, 32 + 19, "R5");
    // R3 group one beats group two
    expect_id(32'h001F_C300, 32'h1, 32'h1, 1, 32 + 19, "R3");
    // R6 each entry of group two
    for (int k = 0; k < 6; k++) begin
      int l2 [6] = '{21, 22, 23, 24, 25, 30};
      expect_id(32'h1 << (15 + k), 0, 0, 1, 64 + l2[k], "R6");
    end
    // R7 bank scans, and bit 8 beats bit 9
    expect_id(32'h0000_0300, 32'h8000_0100, 32'h1, 1, 32 + 8, "R7");
    expect_id(32'h0000_0200, 32'h1, 32'h0040_0000, 1, 64 + 22, "R7");
    // R8 nothing live, high bits ignored
    expect_id(32'hFFE0_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R8");
    // R11 fault held several cycles, then switch fault bank without a gap
    step(32'h0000_0100, 0, 32'h5, 1'b1, "R11");
    repeat (4) step(32'h0000_0100, 0, 32'h5, 1'b1, "R11");
    repeat (3) step(32'h0000_0200, 32'h3, 0, 1'b1, "R11");
    step(0, 0, 0, 1'b1, "R11");
    step(32'h0000_0200, 0, 0, 1'b1, "R11");
    step(0, 0, 0, 1'b1, "R11");
    // R10 stall while inputs move, fault arriving mid-stall
    step(32'h0000_0004, 0, 0, 1'b1, "R10");
    step(32'h0000_0001, 0, 0, 1'b0, "R10");
    step(32'h0000_0100, 0, 0, 1'b0, "R10");
    step(32'h0000_0800, 0, 0, 1'b0, "R10");
    step(32'h0000_0800, 0, 0, 1'b1, "R10");
    step(0, 0, 0, 1'b1, "R10");
    // R9 sparse random patterns with ready bursts
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] s, b1, b2;
      s  = $urandom & $urandom & $urandom;
      b1 = ($urandom % 4 == 0) ? 32'h0 : ($urandom & $urandom & $urandom);
      b2 = ($urandom % 4 == 0) ? 32'h0 : ($urandom & $urandom & $urandom);
      if ($urandom % 3 == 0) s = s & 32'hFFFF_FC00;
      if ($urandom % 3 == 0) s = s & 32'hFFE0_03FF;
      step(s, b1, b2, ($urandom % 4) != 0, "R9");
    end
    step(0, 0, 0, 1'b1, "R9");
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule